// File: doc/BRIEF.md
# Zero-Address Stack Evaluator

This block runs a short evolved straight-line program in which every calculation goes through a hardware stack. Four instruction kinds exist. A push copies an external input port or an internal spill register onto the stack. A pop moves the top entry into a spill register. An add or a multiply takes the two topmost entries and leaves their sum or product in their place. The spill registers hold sub-results only; no arithmetic reads them directly.

A host loads a program into an external memory and pulses `start` with the program length. The evaluator then fetches one instruction per cycle through an asynchronous read port. After the last instruction it pops the top of stack into `result` and pulses `done`. A push onto a full stack and an arithmetic step with too few operands are both absorbed without changing the stack, and each one raises its own sticky flag. This lets a fitness evaluator score malformed individuals without stalling.

Top module: `stack_eval`

## Requirements
- R1: After reset, `busy`, `done`, `overflow` and `underflow` are 0 and `result` is 0.
- R2: The instruction word is {class[OPW+2:OPW+1], sel[OPW], idx[OPW-1:0]}. Class 00 is a push. With sel=1 it pushes input port idx, taken from `port_data[idx*W +: W]`. With sel=0 it pushes spill register idx.
- R3: Class 01 is a pop. It moves the top entry into spill register idx and ignores sel. All spill registers read 0 after each accepted start.
- R4: Class 10 (add) and class 11 (multiply) replace the two top entries with their sum or product, truncated modulo 2^W, so the stack shrinks by one.
- R5: A push when DEPTH entries are already held is dropped, leaves the stack unchanged, and sets `overflow`. The flag stays set until the next accepted start.
- R6: An add or multiply with fewer than two entries, or a pop from an empty stack, leaves the stack and the registers unchanged and sets `underflow`. The flag stays set until the next accepted start.
- R7: For a program of length L accepted at clock edge E0, instruction k executes at edge E(k+1). `done` is high for exactly one cycle, following edge E(L+1), and `busy` is high from E0 until that edge.
- R8: At completion, `result` takes the top entry and holds it until the next completion. If the stack is empty, `result` becomes 0 and `underflow` is set.
- R9: `start` is accepted only while not busy. An accepted start clears the stack, the spill registers and both flags. A start while busy has no effect.
- R10: A program length of 0 executes nothing and completes one edge after the start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin executing a program |
| prog_len | input | AW+1 | Number of instructions, 0 to 2^AW |
| imem_addr | output | AW | Program memory address |
| imem_data | input | OPW+3 | Instruction read combinationally at imem_addr |
| port_data | input | W*2^OPW | Packed input ports, port i at bits [i*W +: W] |
| busy | output | 1 | Program in progress |
| done | output | 1 | One-cycle completion pulse |
| result | output | W | Value popped at completion |
| overflow | output | 1 | Sticky full-stack push flag |
| underflow | output | 1 | Sticky missing-operand flag |

## Verification
A program of length L started at edge E0 has its answer, flags and `done` due after edge E(L+1). The bench counts falling edges from the start: `busy` must read high at the first one, and `done` must first read high at the (L+2)-th. It samples `result` and both flags at that same falling edge, and checks at the next one that `done` has dropped. A second `start` raised one edge into a run must not move that count. The flags are read only at completion, so every check is taken half a cycle clear of the edge that produced the value.

// File: rtl/stack_eval.sv
module stack_eval #(
  parameter int W     = 16,
  parameter int DEPTH = 8,
  parameter int OPW   = 2,
  parameter int AW    = 6
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    start,
  input  logic [AW:0]             prog_len,
  output logic [AW-1:0]           imem_addr,
  input  logic [OPW+2:0]          imem_data,
  input  logic [W*(2**OPW)-1:0]   port_data,
  output logic                    busy,
  output logic                    done,
  output logic [W-1:0]            result,
  output logic                    overflow,
  output logic                    underflow
);
  localparam int NREG = 2 ** OPW;
  localparam int SPW  = $clog2(DEPTH + 1);
  localparam int IXW  = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [SPW-1:0] FULL = SPW'(DEPTH);

  typedef enum logic [1:0] {S_IDLE, S_RUN, S_FIN} st_t;
  localparam logic [1:0] C_PUSH = 2'b00, C_POP = 2'b01, C_ADD = 2'b10, C_MUL = 2'b11;

  st_t            state;
  logic [AW-1:0]  pc;
  logic [AW:0]    len;
  logic [SPW-1:0] sp;
  logic [W-1:0]   stk  [DEPTH];
  logic [W-1:0]   regs [NREG];

  logic [1:0]     cls;
  logic           sel;
  logic [OPW-1:0] idx;
  logic [SPW-1:0] sp_m1, sp_m2;
  logic [W-1:0]   top, nxt, src, alu;
  logic           last;

  assign cls   = imem_data[OPW+2:OPW+1];
  assign sel   = imem_data[OPW];
  assign idx   = imem_data[OPW-1:0];
  assign sp_m1 = sp - SPW'(1);
  assign sp_m2 = sp - SPW'(2);
  assign top   = (sp != '0) ? stk[sp_m1[IXW-1:0]] : '0;
  assign nxt   = (sp > SPW'(1)) ? stk[sp_m2[IXW-1:0]] : '0;
  assign src   = sel ? port_data[idx*W +: W] : regs[idx];
  assign alu   = (cls == C_MUL) ? nxt * top : nxt + top;
  assign last  = ({1'b0, pc} == len - 1'b1);

  assign imem_addr = pc;
  assign busy      = (state != S_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      pc        <= '0;
      len       <= '0;
      sp        <= '0;
      done      <= 1'b0;
      result    <= '0;
      overflow  <= 1'b0;
      underflow <= 1'b0;
      for (int i = 0; i < DEPTH; i++) stk[i] <= '0;
      for (int i = 0; i < NREG; i++) regs[i] <= '0;
    end else begin
      done <= 1'b0;
      case (state)
        S_IDLE: if (start) begin
          pc        <= '0;
          len       <= prog_len;
          sp        <= '0;
          overflow  <= 1'b0;
          underflow <= 1'b0;
          for (int i = 0; i < NREG; i++) regs[i] <= '0;
          state     <= (prog_len == '0) ? S_FIN : S_RUN;
        end
        S_RUN: begin
          case (cls)
            C_PUSH:
              if (sp == FULL) overflow <= 1'b1;
              else begin
                stk[sp[IXW-1:0]] <= src;
                sp <= sp + SPW'(1);
              end
            C_POP:
              if (sp == '0) underflow <= 1'b1;
              else begin
                regs[idx] <= top;
                sp <= sp_m1;
              end
            default:
              if (sp < SPW'(2)) underflow <= 1'b1;
              else begin
                stk[sp_m2[IXW-1:0]] <= alu;
                sp <= sp_m1;
              end
          endcase
          pc <= pc + AW'(1);
          if (last) state <= S_FIN;
        end
        default: begin
          done  <= 1'b1;
          state <= S_IDLE;
          if (sp == '0) begin
            result    <= '0;
            underflow <= 1'b1;
          end else begin
            result <= top;
            sp     <= sp_m1;
          end
        end
      endcase
    end
  end

  a_r7_done_pulse: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done);
  a_r7_done_idle:  assert property (@(posedge clk) disable iff (!rst_n) done |-> !busy);
  a_r5_no_overflow: assert property (@(posedge clk) disable iff (!rst_n) sp <= FULL);
  a_r5_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n) (busy && overflow) |=> overflow);
  a_r6_unf_sticky: assert property (@(posedge clk) disable iff (!rst_n) (busy && underflow) |=> underflow);
  a_r9_start_only: assert property (@(posedge clk) disable iff (!rst_n) $rose(busy) |-> $past(start));
  a_r2_push_grows: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_RUN && cls == C_PUSH && sp != FULL) |=> sp == $past(sp) + SPW'(1));
  a_r6_short_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_RUN && cls[1] && sp < SPW'(2)) |=> ($stable(sp) && underflow));
endmodule

// File: tb/tb_stack_eval.sv
module tb_stack_eval;
  localparam int W = 16, DEPTH = 8, OPW = 2, AW = 6, NP = 4;

  logic clk = 0, rst_n = 0, start = 0;
  logic [AW:0] prog_len = '0;
  logic [AW-1:0] imem_addr;
  logic [OPW+2:0] imem_data;
  logic [W*NP-1:0] port_data;
  logic busy, done, overflow, underflow;
  logic [W-1:0] result;

  logic [OPW+2:0] prog [64];
  logic [W-1:0] pv [NP];
  int n_chk = 0, n_bad = 0;

  assign imem_data = prog[imem_addr];
  assign port_data = {pv[3], pv[2], pv[1], pv[0]};

  stack_eval #(.W(W), .DEPTH(DEPTH), .OPW(OPW), .AW(AW)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .prog_len(prog_len),
    .imem_addr(imem_addr), .imem_data(imem_data), .port_data(port_data),
    .busy(busy), .done(done), .result(result), .overflow(overflow), .underflow(underflow));

  always #5 clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [4:0] ins(input logic [1:0] c, input logic s, input logic [1:0] i);
    return {c, s, i};
  endfunction

  task automatic model(input int len, output logic [W-1:0] r, output logic o, output logic u);
    logic [W-1:0] st [DEPTH];
    logic [W-1:0] rg [NP];
    int sp = 0;
    o = 0; u = 0;
    for (int i = 0; i < NP; i++) rg[i] = '0;
    for (int k = 0; k < len; k++) begin
      logic [1:0] c = prog[k][4:3];
      logic [1:0] x = prog[k][1:0];
      if (c == 2'b00) begin
        if (sp == DEPTH) o = 1;
        else begin st[sp] = prog[k][2] ? pv[x] : rg[x]; sp++; end
      end else if (c == 2'b01) begin
        if (sp == 0) u = 1;
        else begin sp--; rg[x] = st[sp]; end
      end else begin
        if (sp < 2) u = 1;
        else begin
          st[sp-2] = (c == 2'b11) ? st[sp-2] * st[sp-1] : st[sp-2] + st[sp-1];
          sp--;
        end
      end
    end
    if (sp == 0) begin r = '0; u = 1; end else r = st[sp-1];
  endtask

  task automatic run(input int len, input string req, input bit restart);
    logic [W-1:0] er; logic eo, eu; int n;
    model(len, er, eo, eu);
    @(negedge clk); prog_len = (AW+1)'(len); start = 1;
    @(negedge clk); start = restart; n = 1;
    check({req, " R7 busy"}, busy, 1);
    while (!done && n < 300) begin
      @(negedge clk); start = 0; n++;
    end
    check({req, " R7 done cycle"}, n, len + 2);
    check({req, " R8 result"}, result, er);
    check({req, " R5 overflow"}, overflow, eo);
    check({req, " R6 underflow"}, underflow, eu);
    @(negedge clk);
    check({req, " R7 done pulse"}, {busy, done}, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++; n_chk++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    for (int i = 0; i < 64; i++) prog[i] = '0;
    for (int i = 0; i < NP; i++) pv[i] = W'(i + 2);
    repeat (3) @(negedge clk);
    check("R1 reset", {busy, done, overflow, underflow, result}, 0);
    rst_n = 1;

    // R2 R3 R4: p0*p0 spilled, then (x*x)+p1 with register reload
    pv[0] = 16'd7; pv[1] = 16'd5;
    prog[0] = ins(2'b00, 1, 0); prog[1] = ins(2'b00, 1, 0); prog[2] = ins(2'b11, 0, 0);
    prog[3] = ins(2'b01, 0, 2); prog[4] = ins(2'b00, 0, 2); prog[5] = ins(2'b00, 1, 1);
    prog[6] = ins(2'b10, 0, 0); prog[7] = ins(2'b00, 0, 2); prog[8] = ins(2'b10, 0, 0);
    run(9, "R2 R3 R4 directed", 0);
    check("R3 spill value 49+5+49", result, 103);

    // R4 wrap of multiply and add
    pv[2] = 16'hFFFF; pv[3] = 16'h8001;
    prog[0] = ins(2'b00, 1, 2); prog[1] = ins(2'b00, 1, 3); prog[2] = ins(2'b11, 0, 0);
    prog[3] = ins(2'b00, 1, 3); prog[4] = ins(2'b10, 0, 0);
    run(5, "R4 wrap", 0);
    check("R4 wrap value", result, 16'h0000);

    // R5 overflow: ten pushes, last two dropped
    for (int k = 0; k < 10; k++) prog[k] = ins(2'b00, 1, 2'(k));
    run(10, "R5 overflow", 0);

    // R9 flags cleared by a fresh start; R3 registers cleared
    prog[0] = ins(2'b00, 0, 3);
    run(1, "R9 clear", 0);
    check("R9 cleared regs", result, 0);

    // R6 underflow on add with one entry, and pop from empty
    prog[0] = ins(2'b01, 0, 1); prog[1] = ins(2'b00, 1, 1); prog[2] = ins(2'b11, 0, 0);
    run(3, "R6 underflow", 0);
    check("R6 stack kept", result, pv[1]);

    // R10 empty program, R8 empty stack result
    run(0, "R10 empty", 0);

    // R9 start while busy ignored
    for (int k = 0; k < 6; k++) prog[k] = ins(2'b00, 1, 2'(k));
    prog[6] = ins(2'b10, 0, 0);
    run(7, "R9 restart ignored", 1);

    // random programs
    for (int t = 0; t < 60; t++) begin
      int len = $urandom_range(1, 24);
      for (int i = 0; i < NP; i++) pv[i] = W'($urandom);
      for (int k = 0; k < len; k++) begin
        int p = $urandom_range(0, 9);
        logic [1:0] c = (p < 5) ? 2'b00 : (p < 7) ? 2'b01 : (p < 8) ? 2'b10 : 2'b11;
        prog[k] = ins(c, 1'($urandom), 2'($urandom));
      end
      run(len, "R2-random", 0);
    end

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule